// File: doc/BRIEF.md
# Parallel MPU-Bus Panel Write/Read Engine

This block sits between a CPU-side request port and a display panel wired for an 8080-style parallel microprocessor bus. The host hands it one request at a time: a command word, a data word, a mode (configuration) word, or a read trigger. The engine turns each command, data or read request into strobed bus cycles on an 18-pin data bus. It drives chip select, the data/command select line, an active-low write strobe and an active-low read strobe.

A mode word chooses how a host word is laid onto the pins. The choices are an 8-bit lane, a 9-bit lane that sends a 16-bit pixel word as two transfers, a 16-bit split lane, or a straight 18-bit lane. The same word sets the strobe length. A status byte reports whether a transfer is still in flight, whether a mode word may be written now, and whether a read byte is waiting.

The request port is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While the engine is busy, `req_ready` stays low and the host must hold the request and its fields stable until it is taken. Nothing is dropped. Status and pin signals are plain levels.

Top module: `lcd_mpu_bridge`

## Requirements
- R1: After reset, chip select, write strobe and read strobe are high, the data pins and output enable are low, and `req_ready` is high. The status byte reads 0x02: bit 1 (idle) set, bit 4 (busy) clear, bit 0 (read valid) clear. The mode is 8-bit lane with a strobe length of 3.
- R2: Request kind 0 is a command and drives `pin_dc` low during its transfer. Kind 1 is data and drives `pin_dc` high. `pin_cs_n` is low for the whole transfer, including the hold time after each strobe.
- R3: In 8-bit lane mode (mode code 0), host bits [7:0] appear on D[8:1] and every other pin is 0, in one transfer.
- R4: In 16-bit lane mode (mode code 2), host bits [15:8] appear on D[17:10] and bits [7:0] on D[8:1], with D[9] and D[0] at 0, in one transfer.
- R5: In 9-bit lane mode (mode code 1), each command or data word makes two transfers on D[8:1]. Host bits [15:8] go out first and bits [7:0] second.
- R6: In 18-bit lane mode (mode code 3), host bits [17:0] drive D[17:0] directly in one transfer.
- R7: Each strobe is low for T clocks and is followed by T clocks with the strobe high and chip select still low. T is the mode word field [7:4]; a field value of 0 acts as 1.
- R8: Once a command, data or read request is taken, status bit 4 is high and bit 1 is low for exactly 2·T clocks per transfer. `req_ready` is low for that time. A request presented during that time stalls and is carried out unchanged afterwards.
- R9: Request kind 2 loads the mode word: bits [1:0] give the lane mode and bits [7:4] the strobe length. It takes one clock and causes no bus activity.
- R10: Request kind 3 starts a read. `pin_rd_n` is low for T clocks with `pin_dc` high and output enable low. The pins are captured on the last low clock, and `rd_byte` returns pins D[8:1]. Status bit 0 is cleared when a read is taken, set when it completes, and left unchanged by writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Engine can take a request this cycle |
| req_kind | input | 2 | 0 command, 1 data, 2 mode word, 3 read trigger |
| req_word | input | 18 | Request payload |
| status | output | 8 | Bit 0 read valid, bit 1 idle, bit 4 busy, others 0 |
| rd_byte | output | 8 | Last captured D[8:1] |
| pin_cs_n | output | 1 | Panel chip select, active low |
| pin_dc | output | 1 | Data (1) / command (0) select |
| pin_wr_n | output | 1 | Write strobe, active low |
| pin_rd_n | output | 1 | Read strobe, active low |
| pin_oe | output | 1 | Data pin output enable |
| pin_dout | output | 18 | Data pins, driven side |
| pin_din | input | 18 | Data pins, sampled side |

## Verification
The bench checks pin placement in every lane mode. A swapped or shifted byte would land on D[17:10] or D[8:1] in the wrong place, or leave D[0] or D[9] set. In 9-bit mode it checks that the high byte goes out first and that a second strobe occurs at all. Strobe and hold widths are measured against the mode field, including a field of 0, where a design with no floor would run a zero-length or wrapped strobe. A request held against a busy engine must come out intact as its own transfer, not lost or merged with the one before. The read path must return the pins shifted down by one and keep its valid flag across writes.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  localparam int PIN_W  = 18;
  localparam int BYTE_W = 8;
  localparam int STS_W  = 8;
  // mode word field positions
  localparam int MODE_LSB   = 0;
  localparam int STROBE_LSB = 4;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_DATA = 2'd1,
    K_CFG  = 2'd2,
    K_READ = 2'd3
  } req_kind_t;

  typedef enum logic [1:0] {
    LW_8   = 2'd0,
    LW_9X2 = 2'd1,
    LW_16  = 2'd2,
    LW_18  = 2'd3
  } lane_mode_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACT  = 2'd1,
    PH_HOLD = 2'd2
  } phase_t;
endpackage

// File: rtl/mpb_mode_reg.sv
module mpb_mode_reg
  import mpb_pkg::*;
#(
  parameter int STW        = 4,
  parameter int DEF_STROBE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PIN_W-1:0] wr_word,
  output lane_mode_t       lane_mode,
  output logic [STW-1:0]   strobe_len
);
  logic [STW-1:0] strobe_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_mode  <= LW_8;
      strobe_raw <= STW'(DEF_STROBE);
    end else if (wr_en) begin
      lane_mode  <= lane_mode_t'(wr_word[MODE_LSB +: 2]);
      strobe_raw <= wr_word[STROBE_LSB +: STW];
    end
  end

  // a zero field acts as the shortest legal strobe
  assign strobe_len = (strobe_raw == '0) ? STW'(1) : strobe_raw;

  p_strobe_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_len != '0);
endmodule

// File: rtl/mpb_lane_map.sv
module mpb_lane_map
  import mpb_pkg::*;
(
  input  lane_mode_t       lane_mode,
  input  logic             beat,
  input  logic [PIN_W-1:0] word,
  output logic [PIN_W-1:0] pins
);
  localparam int LO_LSB = 1;
  localparam int HI_LSB = 10;

  always_comb begin
    pins = '0;
    unique case (lane_mode)
      LW_8:   pins[LO_LSB +: BYTE_W] = word[7:0];
      LW_9X2: pins[LO_LSB +: BYTE_W] = beat ? word[7:0] : word[15:8];
      LW_16: begin
        pins[HI_LSB +: BYTE_W] = word[15:8];
        pins[LO_LSB +: BYTE_W] = word[7:0];
      end
      LW_18:  pins = word;
      default: pins = '0;
    endcase
  end
endmodule

// File: rtl/mpb_phase_timer.sv
module mpb_phase_timer #(
  parameter int STW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [STW-1:0] load_val,
  output logic           zero
);
  logic [STW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_timer_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/lcd_mpu_bridge.sv
module lcd_mpu_bridge
  import mpb_pkg::*;
#(
  parameter int STW        = 4,
  parameter int DEF_STROBE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [17:0]       req_word,
  output logic [7:0]        status,
  output logic [7:0]        rd_byte,
  output logic              pin_cs_n,
  output logic              pin_dc,
  output logic              pin_wr_n,
  output logic              pin_rd_n,
  output logic              pin_oe,
  output logic [17:0]       pin_dout,
  input  logic [17:0]       pin_din
);
  phase_t           ph;
  logic             beat;
  req_kind_t        kind_q;
  logic [PIN_W-1:0] word_q;
  logic [PIN_W-1:0] cap_q;
  logic             rd_valid;
  lane_mode_t       lane_mode;
  logic [STW-1:0]   strobe_len;
  logic [PIN_W-1:0] mapped;
  logic             tmr_zero;
  logic             tmr_load;
  logic             accept, cfg_wr, xfer_start, idle, two_beat, is_read;

  assign idle       = (ph == PH_IDLE);
  assign req_ready  = idle;
  assign accept     = req_valid && req_ready;
  assign cfg_wr     = accept && (req_kind_t'(req_kind) == K_CFG);
  assign xfer_start = accept && (req_kind_t'(req_kind) != K_CFG);
  assign is_read    = (kind_q == K_READ);
  assign two_beat   = (lane_mode == LW_9X2) && !is_read;
  assign tmr_load   = xfer_start || (!idle && tmr_zero);

  mpb_mode_reg #(.STW(STW), .DEF_STROBE(DEF_STROBE)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr),
    .wr_word    (req_word),
    .lane_mode  (lane_mode),
    .strobe_len (strobe_len)
  );

  mpb_phase_timer #(.STW(STW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (strobe_len - 1'b1),
    .zero     (tmr_zero)
  );

  mpb_lane_map u_map (
    .lane_mode (lane_mode),
    .beat      (beat),
    .word      (word_q),
    .pins      (mapped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      beat     <= 1'b0;
      kind_q   <= K_DATA;
      word_q   <= '0;
      cap_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: if (xfer_start) begin
          ph     <= PH_ACT;
          beat   <= 1'b0;
          kind_q <= req_kind_t'(req_kind);
          word_q <= req_word;
          if (req_kind_t'(req_kind) == K_READ) rd_valid <= 1'b0;
        end
        PH_ACT: if (tmr_zero) begin
          ph <= PH_HOLD;
          if (is_read) cap_q <= pin_din;
        end
        PH_HOLD: if (tmr_zero) begin
          if (two_beat && !beat) begin
            beat <= 1'b1;
            ph   <= PH_ACT;
          end else begin
            ph <= PH_IDLE;
            if (is_read) rd_valid <= 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign pin_cs_n = idle;
  assign pin_wr_n = !((ph == PH_ACT) && !is_read);
  assign pin_rd_n = !((ph == PH_ACT) && is_read);
  assign pin_dc   = !(!idle && (kind_q == K_CMD));
  assign pin_oe   = !idle && !is_read;
  assign pin_dout = pin_oe ? mapped : '0;
  assign rd_byte  = cap_q[1 +: BYTE_W];
  assign status   = {3'b000, !idle, 2'b00, idle, rd_valid};

  // R10: strobes never overlap
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pin_wr_n && !pin_rd_n));
  // R2: chip select covers every strobe
  p_cs_covers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_wr_n || !pin_rd_n) |-> !pin_cs_n);
  // R7: a hold with chip select low follows each write strobe
  p_hold_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_wr_n) |-> !pin_cs_n);
  // R3: pins do not move inside a strobe
  p_dout_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_wr_n && $past(!pin_wr_n)) |-> $stable(pin_dout));
  // R9: the lane mode only changes out of an idle bus
  p_mode_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lane_mode) |-> $past(pin_cs_n));
  // R10: read valid rises only at the end of a read
  p_rdvalid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past((ph == PH_HOLD) && is_read));
endmodule

// File: tb/sim_lcd_mpu_bridge.sv
module sim_lcd_mpu_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [17:0] req_word = '0;
  logic [7:0]  status, rd_byte;
  logic        pin_cs_n, pin_dc, pin_wr_n, pin_rd_n, pin_oe;
  logic [17:0] pin_dout;
  logic [17:0] pin_din = '0;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  lcd_mpu_bridge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_word(req_word), .status(status), .rd_byte(rd_byte),
    .pin_cs_n(pin_cs_n), .pin_dc(pin_dc), .pin_wr_n(pin_wr_n), .pin_rd_n(pin_rd_n),
    .pin_oe(pin_oe), .pin_dout(pin_dout), .pin_din(pin_din)
  );

  // pin monitor, sampled at falling edges
  logic [17:0] m_dout [0:31];
  logic        m_dc   [0:31];
  logic        m_cs   [0:31];
  int          m_low  [0:31];
  int          m_beats = 0;
  int          r_low  [0:31];
  logic        r_dc   [0:31];
  logic        r_oe   [0:31];
  int          r_beats = 0;
  int          cs_cycles = 0;
  logic        prev_wr = 1'b1, prev_rd = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!pin_cs_n) cs_cycles <= cs_cycles + 1;
      if (!pin_wr_n) begin
        if (prev_wr) begin
          m_dout[m_beats % 32] = pin_dout;
          m_dc[m_beats % 32]   = pin_dc;
          m_cs[m_beats % 32]   = pin_cs_n;
          m_low[m_beats % 32]  = 1;
          m_beats = m_beats + 1;
        end else begin
          m_low[(m_beats - 1) % 32] = m_low[(m_beats - 1) % 32] + 1;
        end
      end
      if (!pin_rd_n) begin
        if (prev_rd) begin
          r_dc[r_beats % 32]  = pin_dc;
          r_oe[r_beats % 32]  = pin_oe;
          r_low[r_beats % 32] = 1;
          r_beats = r_beats + 1;
        end else begin
          r_low[(r_beats - 1) % 32] = r_low[(r_beats - 1) % 32] + 1;
        end
      end
      prev_wr = pin_wr_n;
      prev_rd = pin_rd_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // issue one request and wait until the engine is idle; returns busy clocks
  task automatic xfer(input logic [1:0] kind, input logic [17:0] word, output int busy);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_word = word;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!status[1] && busy < 1000) begin
      busy++;
      @(negedge clk);
    end
  endtask

  function automatic logic [17:0] lo_lane(input logic [7:0] b);
    return {9'b0, b, 1'b0};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(pin_cs_n && pin_wr_n && pin_rd_n, "R1", "strobes/cs idle",
        {pin_cs_n, pin_wr_n, pin_rd_n}, 3'b111);
    chk(pin_dout == 0 && !pin_oe, "R1", "pins quiet", pin_dout, 0);
    chk(status == 8'h02, "R1", "status", status, 8'h02);
    chk(req_ready, "R1", "ready", req_ready, 1);
  endtask

  task automatic t_cmd_data8;
    int b, busy;
    b = m_beats;
    xfer(2'd0, 18'h3_F0A5, busy);
    chk(m_beats == b + 1, "R3", "8-bit beats", m_beats - b, 1);
    chk(m_dout[b % 32] == lo_lane(8'hA5), "R3", "8-bit pins", m_dout[b % 32], lo_lane(8'hA5));
    chk(m_dc[b % 32] == 1'b0, "R2", "command dc", m_dc[b % 32], 0);
    chk(m_cs[b % 32] == 1'b0, "R2", "cs during strobe", m_cs[b % 32], 0);
    chk(m_low[b % 32] == 3, "R7", "default strobe", m_low[b % 32], 3);
    chk(busy == 6, "R8", "busy length T=3", busy, 6);
    b = m_beats;
    xfer(2'd1, 18'h0_005C, busy);
    chk(m_dc[b % 32] == 1'b1, "R2", "data dc", m_dc[b % 32], 1);
    chk(m_dout[b % 32] == lo_lane(8'h5C), "R3", "8-bit data pins", m_dout[b % 32], lo_lane(8'h5C));
  endtask

  task automatic t_width16;
    int b, busy;
    xfer(2'd2, 18'h32, busy);         // 16-bit, T=3
    b = m_beats;
    xfer(2'd1, 18'h1_C3E7, busy);
    chk(m_beats == b + 1, "R4", "16-bit beats", m_beats - b, 1);
    chk(m_dout[b % 32] == {8'hC3, 1'b0, 8'hE7, 1'b0}, "R4", "16-bit pins",
        m_dout[b % 32], {8'hC3, 1'b0, 8'hE7, 1'b0});
  endtask

  task automatic t_width9;
    int b, busy;
    xfer(2'd2, 18'h21, busy);         // 9-bit two-transfer, T=2
    b = m_beats;
    xfer(2'd1, 18'h0_9E4B, busy);
    chk(m_beats == b + 2, "R5", "9-bit beats", m_beats - b, 2);
    chk(m_dout[b % 32] == lo_lane(8'h9E), "R5", "first beat high byte",
        m_dout[b % 32], lo_lane(8'h9E));
    chk(m_dout[(b + 1) % 32] == lo_lane(8'h4B), "R5", "second beat low byte",
        m_dout[(b + 1) % 32], lo_lane(8'h4B));
    chk(busy == 8, "R8", "busy two beats T=2", busy, 8);
    chk(m_low[(b + 1) % 32] == 2, "R7", "strobe T=2", m_low[(b + 1) % 32], 2);
  endtask

  task automatic t_width18;
    int b, busy;
    xfer(2'd2, 18'h53, busy);         // 18-bit, T=5
    b = m_beats;
    xfer(2'd1, 18'h2_D1B6, busy);
    chk(m_dout[b % 32] == 18'h2_D1B6, "R6", "18-bit pins", m_dout[b % 32], 18'h2_D1B6);
    chk(m_low[b % 32] == 5, "R7", "strobe T=5", m_low[b % 32], 5);
    chk(busy == 10, "R8", "busy T=5", busy, 10);
  endtask

  task automatic t_cfg_quiet;
    int b, c, busy;
    b = m_beats; c = cs_cycles;
    xfer(2'd2, 18'h00, busy);         // 8-bit, field 0 -> T=1
    chk(m_beats == b && cs_cycles == c, "R9", "no bus activity on mode write",
        cs_cycles - c, 0);
    chk(busy == 0, "R9", "mode write leaves idle", busy, 0);
    b = m_beats;
    xfer(2'd0, 18'h77, busy);
    chk(m_low[b % 32] == 1 && busy == 2, "R7", "zero field acts as 1",
        {m_low[b % 32][15:0], busy[15:0]}, {16'd1, 16'd2});
  endtask

  task automatic t_stall;
    int b, waits;
    xfer(2'd2, 18'h30, waits);        // 8-bit, T=3
    b = m_beats;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd1; req_word = 18'h11;
    @(negedge clk);                   // first taken at the edge before
    req_word = 18'h0_00E2;
    chk(!req_ready && status[4] && !status[1], "R8", "ready low while busy",
        {req_ready, status[4], status[1]}, 3'b010);
    @(negedge clk);
    chk(pin_dout == lo_lane(8'h11), "R8", "first word on pins while stalled",
        pin_dout, lo_lane(8'h11));
    waits = 0;
    while (!req_ready) begin waits++; @(negedge clk); end
    @(negedge clk);
    req_valid = 1'b0;
    while (!status[1]) @(negedge clk);
    chk(m_beats == b + 2, "R8", "stalled request carried out", m_beats - b, 2);
    chk(m_dout[(b + 1) % 32] == lo_lane(8'hE2), "R8", "stalled word intact",
        m_dout[(b + 1) % 32], lo_lane(8'hE2));
  endtask

  task automatic t_read;
    int b, busy;
    b = r_beats;
    pin_din = 18'h0_01A5;             // D[8:1] = 0xD2
    xfer(2'd3, 18'h0, busy);
    chk(r_beats == b + 1 && r_low[b % 32] == 3, "R10", "read strobe width",
        r_low[b % 32], 3);
    chk(r_dc[b % 32] && !r_oe[b % 32], "R10", "read dc high oe low",
        {r_dc[b % 32], r_oe[b % 32]}, 2'b10);
    chk(status[0] && rd_byte == 8'hD2, "R10", "read byte", rd_byte, 8'hD2);
    pin_din = 18'h3_FFFF;
    xfer(2'd1, 18'h44, busy);
    chk(status[0] && rd_byte == 8'hD2, "R10", "valid kept across write",
        {status[0], rd_byte}, {1'b1, 8'hD2});
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd3; req_word = '0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!status[0], "R10", "valid cleared on new read", status[0], 0);
    while (!status[1]) @(negedge clk);
    chk(status[0] && rd_byte == 8'hFF, "R10", "second read byte", rd_byte, 8'hFF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_cmd_data8;
        t_width16;
        t_width9;
        t_width18;
        t_cfg_quiet;
        t_stall;
        t_read;
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule